// File: doc/BRIEF.md
# Thread Context Halt and Resume Controller

This block holds the program-counter state of a small set of hardware thread contexts in a multithreaded core and carries out halt and resume operations on them. Each context has an active flag and four address registers: the current PC, the next PC, the next-next PC and a restart address. Halting an active context clears its active flag and records the address it must come back to. Resuming an inactive context rebuilds its three-stage PC sequence from that single restart address and sets the active flag again.

Requests arrive as one halt bit and one resume bit per context. Several contexts may be served on the same clock edge. A request that does not match the context's present state is dropped without effect. A single write port lets software or a neighbouring unit load any address field of any context. A registered read port returns any field one cycle after it is addressed. Per-context pulse outputs report every request that was taken.

Top module: `tctx_halt_ctrl`

## Requirements
- R1: A halt request for context i is accepted only while `active_o[i]` is 1. When it is accepted, `active_o[i]` reads 0 after that edge. A halt request for an inactive context changes nothing.
- R2: On an accepted halt, the restart field of the context is loaded with the value its next-PC field held before the edge. The PC, next-PC and next-next-PC fields keep their values.
- R3: A resume request for context i is accepted only while `active_o[i]` is 0. A resume request for an active context changes no field and no flag.
- R4: On an accepted resume, one clock edge loads PC with the restart value, next PC with restart+4 and next-next PC with restart+8, all modulo 2^PC_W, and sets `active_o[i]` to 1.
- R5: When halt and resume are both requested for the same context in one cycle, the resume is discarded and the halt follows R1. For an inactive context this means nothing happens.
- R6: Each accepted halt raises `halt_done_o[i]` and each accepted resume raises `resume_done_o[i]`. Each pulse lasts one cycle and appears in the cycle after the edge that applied the operation. An ignored request raises no pulse.
- R7: A synchronous reset (`rst` high at a clock edge) clears every address field to 0, every active flag to 0, both pulse vectors and `rd_data`.
- R8: With `wr_en` high, the edge writes `wr_data` into field `wr_sel` of context `wr_ctx`. The field codes are 0 = PC, 1 = next PC, 2 = next-next PC and 3 = restart. If a halt or resume is accepted for that same context on that edge, the write is dropped.
- R9: `rd_data` shows field `rd_sel` of context `rd_ctx` as it stood at the sampling edge. It appears one cycle after the address is presented and uses the same field codes as R8.
- R10: Contexts are independent. Requests on several contexts in the same cycle are each handled by R1 to R5, and a write to one context is applied on the same edge as an operation on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | NUM_CTX | Per-context halt request |
| resume_req | input | NUM_CTX | Per-context resume request |
| wr_en | input | 1 | Field write strobe |
| wr_ctx | input | IDX_W | Context addressed by the write |
| wr_sel | input | 2 | Field written (0 PC, 1 next PC, 2 next-next PC, 3 restart) |
| wr_data | input | PC_W | Write value |
| rd_ctx | input | IDX_W | Context addressed by the read |
| rd_sel | input | 2 | Field read (same codes as wr_sel) |
| rd_data | output | PC_W | Registered read value |
| active_o | output | NUM_CTX | Per-context active flag |
| halt_done_o | output | NUM_CTX | One-cycle pulse per accepted halt |
| resume_done_o | output | NUM_CTX | One-cycle pulse per accepted resume |

## Verification
A halt and a resume can land on the same context in the same cycle, and so can a field write and an operation on that context. The bench provokes both collisions on purpose. It raises both request bits on an inactive context and expects no pulse and no change of state. It raises both on an active context and expects a halt. It also writes the next-PC or restart field of a context on the same edge that halts it, then reads back the restart field to confirm that the write was dropped and the pre-edge next PC was stored. A scoreboard model predicts the pulse and active vectors for every cycle and compares them with the outputs one edge later.

// File: rtl/tctx_pkg.sv
package tctx_pkg;

  // Field codes shared by the write and read ports.
  typedef enum logic [1:0] {
    FLD_PC      = 2'd0,
    FLD_NPC     = 2'd1,
    FLD_NNPC    = 2'd2,
    FLD_RESTART = 2'd3
  } tctx_fld_e;

  // Byte distance between consecutive sequential instruction addresses.
  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/tctx_arbiter.sv
// Per-context acceptance logic: decides which requests take effect this edge.
module tctx_arbiter #(
  parameter int NUM_CTX = 4
) (
  input  logic [NUM_CTX-1:0] halt_req,
  input  logic [NUM_CTX-1:0] resume_req,
  input  logic [NUM_CTX-1:0] active,
  output logic [NUM_CTX-1:0] take_halt,
  output logic [NUM_CTX-1:0] take_resume
);

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    always_comb begin
      // Halt acts only on a running context.
      take_halt[g]   = halt_req[g] & active[g];
      // Resume acts only on a stopped context, and loses to a halt request.
      take_resume[g] = resume_req[g] & ~halt_req[g] & ~active[g];
    end
  end

endmodule

// File: rtl/tctx_slot.sv
// State of one thread context: active flag plus four address fields.
module tctx_slot
  import tctx_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_halt,
  input  logic            take_resume,
  input  logic            wr_hit,
  input  logic [1:0]      wr_sel,
  input  logic [PC_W-1:0] wr_data,
  output logic            active,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] npc_q,
  output logic [PC_W-1:0] nnpc_q,
  output logic [PC_W-1:0] restart_q
);

  localparam logic [PC_W-1:0] STEP1 = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INSN_BYTES);

  logic [PC_W-1:0] seq_npc;
  logic [PC_W-1:0] seq_nnpc;

  always_comb begin
    seq_npc  = restart_q + STEP1;
    seq_nnpc = restart_q + STEP2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      pc_q      <= '0;
      npc_q     <= '0;
      nnpc_q    <= '0;
      restart_q <= '0;
    end else if (take_halt) begin
      active    <= 1'b0;
      restart_q <= npc_q;
    end else if (take_resume) begin
      active    <= 1'b1;
      pc_q      <= restart_q;
      npc_q     <= seq_npc;
      nnpc_q    <= seq_nnpc;
    end else if (wr_hit) begin
      unique case (tctx_fld_e'(wr_sel))
        FLD_PC:      pc_q      <= wr_data;
        FLD_NPC:     npc_q     <= wr_data;
        FLD_NNPC:    nnpc_q    <= wr_data;
        FLD_RESTART: restart_q <= wr_data;
        default:     pc_q      <= pc_q;
      endcase
    end
  end

endmodule

// File: rtl/tctx_read_port.sv
// Registered field read across all contexts.
module tctx_read_port
  import tctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int PC_W    = 32,
  parameter int IDX_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDX_W-1:0] rd_ctx,
  input  logic [1:0]      rd_sel,
  input  logic [PC_W-1:0] pc_a      [NUM_CTX],
  input  logic [PC_W-1:0] npc_a     [NUM_CTX],
  input  logic [PC_W-1:0] nnpc_a    [NUM_CTX],
  input  logic [PC_W-1:0] restart_a [NUM_CTX],
  output logic [PC_W-1:0] rd_data
);

  logic [PC_W-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (rd_ctx == IDX_W'(k)) begin
        unique case (tctx_fld_e'(rd_sel))
          FLD_PC:      sel_val = pc_a[k];
          FLD_NPC:     sel_val = npc_a[k];
          FLD_NNPC:    sel_val = nnpc_a[k];
          FLD_RESTART: sel_val = restart_a[k];
          default:     sel_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel_val;
  end

endmodule

// File: rtl/tctx_halt_ctrl.sv
// Top: halt/resume controller for NUM_CTX hardware thread contexts.
module tctx_halt_ctrl #(
  parameter int NUM_CTX = 4,
  parameter int PC_W    = 32,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CTX-1:0] halt_req,
  input  logic [NUM_CTX-1:0] resume_req,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_ctx,
  input  logic [1:0]         wr_sel,
  input  logic [PC_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]   rd_ctx,
  input  logic [1:0]         rd_sel,
  output logic [PC_W-1:0]    rd_data,
  output logic [NUM_CTX-1:0] active_o,
  output logic [NUM_CTX-1:0] halt_done_o,
  output logic [NUM_CTX-1:0] resume_done_o
);

  logic [NUM_CTX-1:0] take_halt;
  logic [NUM_CTX-1:0] take_resume;
  logic [NUM_CTX-1:0] wr_hit;
  logic [PC_W-1:0]    pc_a      [NUM_CTX];
  logic [PC_W-1:0]    npc_a     [NUM_CTX];
  logic [PC_W-1:0]    nnpc_a    [NUM_CTX];
  logic [PC_W-1:0]    restart_a [NUM_CTX];

  tctx_arbiter #(.NUM_CTX(NUM_CTX)) u_arb (
    .halt_req    (halt_req),
    .resume_req  (resume_req),
    .active      (active_o),
    .take_halt   (take_halt),
    .take_resume (take_resume)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    always_comb wr_hit[g] = wr_en && (wr_ctx == IDX_W'(g));

    tctx_slot #(.PC_W(PC_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .take_halt   (take_halt[g]),
      .take_resume (take_resume[g]),
      .wr_hit      (wr_hit[g]),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .active      (active_o[g]),
      .pc_q        (pc_a[g]),
      .npc_q       (npc_a[g]),
      .nnpc_q      (nnpc_a[g]),
      .restart_q   (restart_a[g])
    );
  end

  tctx_read_port #(.NUM_CTX(NUM_CTX), .PC_W(PC_W), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_ctx    (rd_ctx),
    .rd_sel    (rd_sel),
    .pc_a      (pc_a),
    .npc_a     (npc_a),
    .nnpc_a    (nnpc_a),
    .restart_a (restart_a),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_done_o   <= '0;
      resume_done_o <= '0;
    end else begin
      halt_done_o   <= take_halt;
      resume_done_o <= take_resume;
    end
  end

endmodule

// File: rtl/tctx_halt_ctrl_chk.sv
// Port-level checker bound to the controller.
module tctx_halt_ctrl_chk #(
  parameter int NUM_CTX = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CTX-1:0] halt_req,
  input logic [NUM_CTX-1:0] resume_req,
  input logic [NUM_CTX-1:0] active_o,
  input logic [NUM_CTX-1:0] halt_done_o,
  input logic [NUM_CTX-1:0] resume_done_o
);

  p_halt_needs_active_r1: assert property (@(posedge clk) disable iff (rst)
    (halt_done_o & ~$past(active_o)) == '0);

  p_halt_deactivates_r1: assert property (@(posedge clk) disable iff (rst)
    (halt_done_o & active_o) == '0);

  p_resume_needs_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (resume_done_o & $past(active_o)) == '0);

  p_resume_activates_r4: assert property (@(posedge clk) disable iff (rst)
    (resume_done_o & ~active_o) == '0);

  p_halt_beats_resume_r5: assert property (@(posedge clk) disable iff (rst)
    (resume_done_o & $past(halt_req)) == '0);

  p_done_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    (halt_done_o & resume_done_o) == '0);

  p_halt_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (halt_done_o & ~$past(halt_req)) == '0);

  p_resume_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (resume_done_o & ~$past(resume_req)) == '0);

  p_flag_moves_with_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ((active_o ^ $past(active_o)) & ~(halt_done_o | resume_done_o)) == '0);

endmodule

bind tctx_halt_ctrl tctx_halt_ctrl_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .halt_req      (halt_req),
  .resume_req    (resume_req),
  .active_o      (active_o),
  .halt_done_o   (halt_done_o),
  .resume_done_o (resume_done_o)
);

// File: tb/tctx_halt_ctrl_tb.sv
module tctx_halt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  halt_req = '0, resume_req = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_ctx = '0, rd_ctx = '0;
  logic [1:0]    wr_sel = '0, rd_sel = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic [N-1:0]  active_o, halt_done_o, resume_done_o;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // Reference model of the architectural state.
  logic [W-1:0] m_pc [N], m_npc [N], m_nnpc [N], m_rst [N];
  logic [N-1:0] m_act;
  logic [3*N-1:0] sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tctx_halt_ctrl #(.NUM_CTX(N), .PC_W(W)) u_dut (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mfield(int c, int s);
    case (s)
      0: return m_pc[c];
      1: return m_npc[c];
      2: return m_nnpc[c];
      default: return m_rst[c];
    endcase
  endfunction

  // Driver: one cycle of stimulus; pushes the predicted pulse/flag vectors.
  task automatic drive(logic [N-1:0] h, logic [N-1:0] r, logic we,
                       int wc, int ws, logic [W-1:0] wd);
    logic [N-1:0] th, tr;
    @(negedge clk);
    halt_req = h; resume_req = r; wr_en = we;
    wr_ctx = IW'(wc); wr_sel = 2'(ws); wr_data = wd;
    th = h & m_act;
    tr = r & ~h & ~m_act;
    for (int c = 0; c < N; c++) begin
      if (th[c]) begin
        m_act[c] = 1'b0; m_rst[c] = m_npc[c];
      end else if (tr[c]) begin
        m_act[c] = 1'b1; m_pc[c] = m_rst[c];
        m_npc[c] = m_rst[c] + 4; m_nnpc[c] = m_rst[c] + 8;
      end else if (we && wc == c) begin
        case (ws)
          0: m_pc[c] = wd;
          1: m_npc[c] = wd;
          2: m_nnpc[c] = wd;
          default: m_rst[c] = wd;
        endcase
      end
    end
    sb_q.push_back({th, tr, m_act});
  endtask

  task automatic idle();
    drive('0, '0, 1'b0, 0, 0, '0);
  endtask

  task automatic wr(int c, int s, logic [W-1:0] d);
    drive('0, '0, 1'b1, c, s, d);
  endtask

  // R9: read one field; rd_data is valid after the next edge.
  task automatic rd_chk(string req, int c, int s);
    idle();
    rd_ctx = IW'(c); rd_sel = 2'(s);
    @(posedge clk); #1;
    chk(req, rd_data, mfield(c, s));
  endtask

  // Monitor: compares pulses and flags one edge after each driven cycle.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (sb_q.size() > 0) begin
        logic [3*N-1:0] e;
        e = sb_q.pop_front();
        chk("R6 halt_done", W'(halt_done_o), W'(e[3*N-1:2*N]));
        chk("R6 resume_done", W'(resume_done_o), W'(e[2*N-1:N]));
        chk("R1/R3 active", W'(active_o), W'(e[N-1:0]));
      end else if ((halt_done_o | resume_done_o) != '0) begin
        chk("R6 stray pulse", W'({halt_done_o, resume_done_o}), '0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      m_pc[c] = '0; m_npc[c] = '0; m_nnpc[c] = '0; m_rst[c] = '0;
    end
    m_act = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R7: reset state
    chk("R7 active", W'(active_o), '0);
    chk("R7 pulses", W'({halt_done_o, resume_done_o}), '0);
    for (int c = 0; c < N; c++) rd_chk("R7 restart zero", c, 3);
    rd_chk("R7 pc zero", 0, 0);
    rd_chk("R7 nnpc zero", 3, 2);

    // R8: writes to fields
    wr(0, 3, 32'h0000_1000);
    wr(1, 3, 32'h0000_2000);
    wr(2, 3, 32'hFFFF_FFFC);
    wr(3, 0, 32'h0000_ABC0);
    rd_chk("R8 restart write", 0, 3);
    rd_chk("R8 pc write", 3, 0);

    // R1: halt on an inactive context is ignored
    drive(4'b0001, '0, 1'b0, 0, 0, '0);
    rd_chk("R1 ignored halt restart", 0, 3);

    // R4: resume rebuilds the PC sequence
    drive('0, 4'b0001, 1'b0, 0, 0, '0);
    rd_chk("R4 pc", 0, 0);
    chk("R4 pc literal", rd_data, 32'h0000_1000);
    rd_chk("R4 npc", 0, 1);
    chk("R4 npc literal", rd_data, 32'h0000_1004);
    rd_chk("R4 nnpc", 0, 2);
    chk("R4 nnpc literal", rd_data, 32'h0000_1008);

    // R3: resume on an active context is ignored
    wr(0, 3, 32'h0000_5550);
    drive('0, 4'b0001, 1'b0, 0, 0, '0);
    rd_chk("R3 pc unchanged", 0, 0);

    // R2: halt stores next PC, keeps PCs
    wr(0, 1, 32'h0000_3000);
    drive(4'b0001, '0, 1'b0, 0, 0, '0);
    rd_chk("R2 restart gets npc", 0, 3);
    chk("R2 restart literal", rd_data, 32'h0000_3000);
    rd_chk("R2 pc kept", 0, 0);

    // R4: wrap of the sequence
    drive('0, 4'b0100, 1'b0, 0, 0, '0);
    rd_chk("R4 wrap npc", 2, 1);
    chk("R4 wrap npc literal", rd_data, 32'h0000_0000);
    rd_chk("R4 wrap nnpc", 2, 2);
    chk("R4 wrap nnpc literal", rd_data, 32'h0000_0004);

    // R5: both requests on inactive ctx1 -> nothing; on active ctx2 -> halt
    drive(4'b0010, 4'b0010, 1'b0, 0, 0, '0);
    rd_chk("R5 inactive both pc", 1, 0);
    drive(4'b0100, 4'b0100, 1'b0, 0, 0, '0);
    rd_chk("R5 active both restart", 2, 3);

    // R10: several contexts in one cycle
    drive('0, 4'b0111, 1'b0, 0, 0, '0);
    rd_chk("R10 ctx1 pc", 1, 0);
    rd_chk("R10 ctx0 npc", 0, 1);
    drive(4'b0011, 4'b0100, 1'b1, 3, 1, 32'h0000_7770);
    rd_chk("R10 other-ctx write", 3, 1);

    // R8: write dropped when the same context is operated on
    drive('0, 4'b0001, 1'b1, 0, 1, 32'h0000_DEAD);
    rd_chk("R8 write dropped on resume", 0, 1);
    drive(4'b0001, '0, 1'b1, 0, 3, 32'h0000_BEEF);
    rd_chk("R8 write dropped on halt", 0, 3);
    idle(); idle();

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule